// File: doc/BRIEF.md
# DRAM Refresh Address Counter Self-Test Sequencer

This block drives the row/column strobes, write enable, output enable, multiplexed address and data lines of an asynchronous DRAM. Its purpose is to prove that the DRAM's internal CAS-before-RAS refresh row counter works. It first issues a few RAS-only refresh cycles, which bring the DRAM's counter to a usable state. It then writes a background value to every row at one fixed column, using explicitly addressed writes. Next it runs one CAS-before-RAS read-modify-write cycle per row. In these cycles the DRAM's own counter picks the row, the old value is checked and its complement is written. A final pass reads every row with explicit addresses and checks the complement.

The whole sequence runs twice: first with a background of all zeros, then with a background of all ones. A counter that skips, repeats or sticks therefore leaves a row either read twice or never written, and one of the two checking passes reports it. The first failure is kept: its pass, round, row index and observed word.

Every strobe phase lasts a parameter number of clock cycles. The host pulses `start` once and waits for `done`.

Top module: `dram_cbr_counter_test`

## Requirements
- R1: After `start`, exactly INIT_CYCLES RAS-only refresh cycles come first. Each lowers `ras_n` with row addresses 0 up to INIT_CYCLES-1 on `addr`, and `cas_n` stays high throughout.
- R2: Whenever `cas_n` falls while `ras_n` is low, `addr` carries TEST_COL, zero-extended to the address width.
- R3: In the background pass, every row is written once, in ascending order, with an explicit-address cycle. The cycle lowers `ras_n` with the row on `addr`, then lowers `we_n`, drives `dq_oe`, and lowers `cas_n`. The word written is all zeros in round 0 and all ones in round 1. `we_n` is low only while `ras_n` is low.
- R4: A counter-test cycle runs in this order: `cas_n` falls while `ras_n` is high; `ras_n` falls; `cas_n` rises; `cas_n` falls again with `oe_n` low; `oe_n` rises; `we_n` falls while `dq_oe` drives the complement of the background. `dq_oe` and a low `oe_n` never coincide.
- R5: The counter-test pass issues 2^ROW_W such cycles. Each read must return the background word.
- R6: The verification pass reads every row once, in ascending order, with explicit-address cycles. Each read must return the complement of the background.
- R7: Round 1 repeats the background, counter-test and verification passes with the data inverted. The refresh-cycle phase is not repeated. When the test ends, every row therefore holds all zeros.
- R8: Each phase lasts its programmed count. The test occupies `busy` for INIT_CYCLES*(T_RAS+T_RP) + 2*2^ROW_W*(2*(T_RCD+T_ASC+T_RP)+T_CAS+T_CAC+T_CSR+T_CHR+T_CP+T_CAC+T_OEZ+T_WP+T_RP) cycles.
- R9: The first mismatch sets `fail` and latches four values, which later mismatches leave unchanged. The values are `fail_pass` (2 for the counter-test pass, 3 for the verification pass), `fail_round`, `fail_row` and `fail_data`. In the counter-test pass `fail_row` is the cycle's position within the pass; in the verification pass it is the row address. A new `start` clears all of them.
- R10: `done` rises when round 1 completes, with `busy` low and all strobes high. It holds until the next `start`. A `start` asserted while `busy` is high has no effect on the sequence or its length.
- R11: During reset all strobes are high, `dq_oe` is low, and `busy`, `done` and `fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test when idle or done |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low (both byte strobes) |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | ROW_W | Multiplexed row/column address |
| dq_out | output | DATA_W | Write data |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | DATA_W | Read data from the DRAM |
| busy | output | 1 | Test in progress |
| done | output | 1 | Both rounds finished |
| fail | output | 1 | At least one mismatch seen |
| fail_round | output | 1 | Round of the first mismatch |
| fail_pass | output | 2 | Pass of the first mismatch (2 counter test, 3 verify) |
| fail_row | output | ROW_W | Row index of the first mismatch |
| fail_data | output | DATA_W | Word observed at the first mismatch |

## Verification
The assertions check the cycle-level bus rules on every cycle:
- `we_n` is low only inside a row-active window.
- `dq_oe` is never on while `oe_n` is low.
- The column address is present at every column strobe.
- `done` arrives with all strobes idle.
- A latched failure is never overwritten.
- The phase timer stays at zero once it has expired.

What the assertions cannot show is whether the sequence as a whole is right. The bench therefore runs a DRAM model with its own refresh counter. It reads back the order of explicit writes and reads, the number of refresh and counter-test cycles, the total duration and the final memory contents. Faults are injected into the model (a counter that skips a row, a lost counter-test write), and the bench checks that the latched pass, round, row and data match the values predicted for each fault.

// File: rtl/dram_tst_pkg.sv
package dram_tst_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_ROW,
      PH_ASU,
      PH_COL,
      PH_CBR_CAS,
      PH_CBR_HOLD,
      PH_CBR_CP,
      PH_CBR_RD,
      PH_CBR_GAP,
      PH_CBR_WR,
      PH_PRE,
      PH_DONE
   } phase_t;

   typedef enum logic [1:0] {
      PASS_INIT = 2'd0,
      PASS_BG   = 2'd1,
      PASS_CNT  = 2'd2,
      PASS_VER  = 2'd3
   } pass_t;

endpackage

// File: rtl/dram_tst_timer.sv
module dram_tst_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic             expired
);

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   AST_TMR_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired); // R8

endmodule

// File: rtl/dram_tst_strobe.sv
module dram_tst_strobe
   import dram_tst_pkg::*;
#(
   parameter int ROW_W    = 12,
   parameter int DATA_W   = 16,
   parameter int TEST_COL = 0
) (
   input  phase_t            phase,
   input  pass_t             pass_q,
   input  logic [ROW_W-1:0]  row_idx,
   input  logic              round_q,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [ROW_W-1:0]  addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   localparam logic [ROW_W-1:0] COL_ADDR = ROW_W'(TEST_COL);

   logic bg_wr, ver_rd;
   assign bg_wr  = (pass_q == PASS_BG);
   assign ver_rd = (pass_q == PASS_VER);

   always_comb begin
      ras_n  = 1'b1;
      cas_n  = 1'b1;
      we_n   = 1'b1;
      oe_n   = 1'b1;
      dq_oe  = 1'b0;
      addr   = COL_ADDR;
      dq_out = {DATA_W{round_q}};
      case (phase)
         PH_ROW: begin
            ras_n = 1'b0;
            addr  = row_idx;
         end
         PH_ASU: begin
            ras_n = 1'b0;
            we_n  = !bg_wr;
            dq_oe = bg_wr;
         end
         PH_COL: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
            we_n  = !bg_wr;
            dq_oe = bg_wr;
            oe_n  = !ver_rd;
         end
         PH_CBR_CAS:  cas_n = 1'b0;
         PH_CBR_HOLD: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
         end
         PH_CBR_CP:   ras_n = 1'b0;
         PH_CBR_RD: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
            oe_n  = 1'b0;
         end
         PH_CBR_GAP: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
         end
         PH_CBR_WR: begin
            ras_n  = 1'b0;
            cas_n  = 1'b0;
            we_n   = 1'b0;
            dq_oe  = 1'b1;
            dq_out = {DATA_W{!round_q}};
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dram_tst_check.sv
module dram_tst_check
   import dram_tst_pkg::*;
#(
   parameter int ROW_W  = 12,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  pass_t             pass_q,
   input  logic              round_q,
   input  logic [ROW_W-1:0]  row_idx,
   input  logic [DATA_W-1:0] expect_w,
   input  logic [DATA_W-1:0] obs_w,
   output logic              fail,
   output logic              fail_round,
   output logic [1:0]        fail_pass,
   output logic [ROW_W-1:0]  fail_row,
   output logic [DATA_W-1:0] fail_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail       <= 1'b0;
         fail_round <= 1'b0;
         fail_pass  <= '0;
         fail_row   <= '0;
         fail_data  <= '0;
      end else if (clear) begin
         fail       <= 1'b0;
         fail_round <= 1'b0;
         fail_pass  <= '0;
         fail_row   <= '0;
         fail_data  <= '0;
      end else if (sample && (obs_w != expect_w) && !fail) begin
         fail       <= 1'b1;
         fail_round <= round_q;
         fail_pass  <= pass_q;
         fail_row   <= row_idx;
         fail_data  <= obs_w;
      end
   end

   AST_FIRST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clear) |=> (fail && $stable(fail_row) && $stable(fail_data) && $stable(fail_pass))); // R9

endmodule

// File: rtl/dram_cbr_counter_test.sv
module dram_cbr_counter_test
   import dram_tst_pkg::*;
#(
   parameter int ROW_W       = 12,
   parameter int COL_W       = 8,
   parameter int DATA_W      = 16,
   parameter int TEST_COL    = 0,
   parameter int INIT_CYCLES = 8,
   parameter int TMR_W       = 8,
   parameter int T_RAS       = 4,
   parameter int T_RCD       = 2,
   parameter int T_ASC       = 1,
   parameter int T_CAS       = 3,
   parameter int T_CSR       = 2,
   parameter int T_CHR       = 2,
   parameter int T_CP        = 2,
   parameter int T_CAC       = 3,
   parameter int T_OEZ       = 1,
   parameter int T_WP        = 2,
   parameter int T_RP        = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [ROW_W-1:0]  addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   input  logic [DATA_W-1:0] dq_in,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              fail_round,
   output logic [1:0]        fail_pass,
   output logic [ROW_W-1:0]  fail_row,
   output logic [DATA_W-1:0] fail_data
);

   localparam int TMAX = 1 << TMR_W;
   localparam logic [ROW_W-1:0] INIT_LAST = ROW_W'(INIT_CYCLES - 1);
   localparam logic [ROW_W-1:0] COL_ADDR  = ROW_W'(TEST_COL);
   localparam bit TIMING_OK =
      (T_RAS >= 1) && (T_RAS <= TMAX) && (T_RCD >= 1) && (T_RCD <= TMAX) &&
      (T_ASC >= 1) && (T_ASC <= TMAX) && (T_CAS >= 1) && (T_CAS <= TMAX) &&
      (T_CSR >= 1) && (T_CSR <= TMAX) && (T_CHR >= 1) && (T_CHR <= TMAX) &&
      (T_CP  >= 1) && (T_CP  <= TMAX) && (T_CAC >= 1) && (T_CAC <= TMAX) &&
      (T_OEZ >= 1) && (T_OEZ <= TMAX) && (T_WP  >= 1) && (T_WP  <= TMAX) &&
      (T_RP  >= 1) && (T_RP  <= TMAX);
   localparam bit SHAPE_OK = (COL_W <= ROW_W) && (TEST_COL >= 0) &&
      (TEST_COL < (1 << COL_W)) && (INIT_CYCLES >= 1) && (INIT_CYCLES <= (1 << ROW_W));

   if (!TIMING_OK) begin : g_bad_timing
      initial $fatal(1, "dram_cbr_counter_test: a phase count is outside 1..2**TMR_W");
   end
   if (!SHAPE_OK) begin : g_bad_shape
      initial $fatal(1, "dram_cbr_counter_test: address, column or init count out of range");
   end

   phase_t           phase_q, phase_nx;
   pass_t            pass_q, pass_nx;
   logic             round_q, round_nx;
   logic [ROW_W-1:0] row_q, row_nx;
   logic             expired, idle_like, go, step, last_row, load, sample;
   logic [TMR_W-1:0] load_val;
   logic [DATA_W-1:0] bg_word, expect_w;

   function automatic logic [TMR_W-1:0] phase_len(phase_t p, pass_t ps);
      int d;
      case (p)
         PH_ROW:      d = (ps == PASS_INIT) ? T_RAS : T_RCD;
         PH_ASU:      d = T_ASC;
         PH_COL:      d = (ps == PASS_VER) ? T_CAC : T_CAS;
         PH_CBR_CAS:  d = T_CSR;
         PH_CBR_HOLD: d = T_CHR;
         PH_CBR_CP:   d = T_CP;
         PH_CBR_RD:   d = T_CAC;
         PH_CBR_GAP:  d = T_OEZ;
         PH_CBR_WR:   d = T_WP;
         PH_PRE:      d = T_RP;
         default:     d = 1;
      endcase
      return TMR_W'(d - 1);
   endfunction

   assign idle_like = (phase_q == PH_IDLE) || (phase_q == PH_DONE);
   assign go        = idle_like && start;
   assign step      = !idle_like && expired;
   assign last_row  = (pass_q == PASS_INIT) ? (row_q == INIT_LAST) : (&row_q);

   always_comb begin
      phase_nx = phase_q;
      pass_nx  = pass_q;
      round_nx = round_q;
      row_nx   = row_q;
      if (go) begin
         phase_nx = PH_ROW;
         pass_nx  = PASS_INIT;
         round_nx = 1'b0;
         row_nx   = '0;
      end else if (step) begin
         case (phase_q)
            PH_ROW:      phase_nx = (pass_q == PASS_INIT) ? PH_PRE : PH_ASU;
            PH_ASU:      phase_nx = PH_COL;
            PH_COL:      phase_nx = PH_PRE;
            PH_CBR_CAS:  phase_nx = PH_CBR_HOLD;
            PH_CBR_HOLD: phase_nx = PH_CBR_CP;
            PH_CBR_CP:   phase_nx = PH_CBR_RD;
            PH_CBR_RD:   phase_nx = PH_CBR_GAP;
            PH_CBR_GAP:  phase_nx = PH_CBR_WR;
            PH_CBR_WR:   phase_nx = PH_PRE;
            PH_PRE: begin
               if (!last_row) begin
                  row_nx   = row_q + 1'b1;
                  phase_nx = (pass_q == PASS_CNT) ? PH_CBR_CAS : PH_ROW;
               end else begin
                  row_nx = '0;
                  case (pass_q)
                     PASS_INIT: begin pass_nx = PASS_BG;  phase_nx = PH_ROW;     end
                     PASS_BG:   begin pass_nx = PASS_CNT; phase_nx = PH_CBR_CAS; end
                     PASS_CNT:  begin pass_nx = PASS_VER; phase_nx = PH_ROW;     end
                     default: begin
                        if (round_q) phase_nx = PH_DONE;
                        else begin
                           round_nx = 1'b1;
                           pass_nx  = PASS_BG;
                           phase_nx = PH_ROW;
                        end
                     end
                  endcase
               end
            end
            default: ;
         endcase
      end
   end

   assign load     = (phase_nx != phase_q);
   assign load_val = phase_len(phase_nx, pass_nx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         pass_q  <= PASS_INIT;
         round_q <= 1'b0;
         row_q   <= '0;
      end else begin
         phase_q <= phase_nx;
         pass_q  <= pass_nx;
         round_q <= round_nx;
         row_q   <= row_nx;
      end
   end

   dram_tst_timer #(.TMR_W(TMR_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
   );

   dram_tst_strobe #(.ROW_W(ROW_W), .DATA_W(DATA_W), .TEST_COL(TEST_COL)) i_strobe (
      .phase(phase_q), .pass_q(pass_q), .row_idx(row_q), .round_q(round_q),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   assign bg_word  = {DATA_W{round_q}};
   assign expect_w = (pass_q == PASS_CNT) ? bg_word : ~bg_word;
   assign sample   = step && (((phase_q == PH_COL) && (pass_q == PASS_VER)) ||
                              (phase_q == PH_CBR_RD));

   dram_tst_check #(.ROW_W(ROW_W), .DATA_W(DATA_W)) i_check (
      .clk(clk), .rst_n(rst_n), .clear(go), .sample(sample),
      .pass_q(pass_q), .round_q(round_q), .row_idx(row_q),
      .expect_w(expect_w), .obs_w(dq_in),
      .fail(fail), .fail_round(fail_round), .fail_pass(fail_pass),
      .fail_row(fail_row), .fail_data(fail_data)
   );

   assign busy = !idle_like;
   assign done = (phase_q == PH_DONE);

   AST_WE_INSIDE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !ras_n); // R3
   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> oe_n); // R4
   AST_COL_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && $fell(cas_n)) |-> (addr == COL_ADDR)); // R2
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ras_n && cas_n && we_n && oe_n && !busy)); // R10

endmodule

// File: tb/test_dram_cbr_counter_test.sv
`timescale 1ns/1ps
module test_dram_cbr_counter_test;

   localparam int RW = 6, CW = 4, DW = 16, TCOL = 5, NINIT = 8;
   localparam int T_RAS = 3, T_RCD = 2, T_ASC = 1, T_CAS = 2, T_CSR = 1, T_CHR = 2;
   localparam int T_CP = 1, T_CAC = 2, T_OEZ = 1, T_WP = 2, T_RP = 2;
   localparam int N = 1 << RW;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic ras_n, cas_n, we_n, oe_n, dq_oe, busy, done, fail, fail_round;
   logic [RW-1:0] addr, fail_row;
   logic [DW-1:0] dq_out, dq_in, fail_data;
   logic [1:0] fail_pass;

   dram_cbr_counter_test #(
      .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .TEST_COL(TCOL), .INIT_CYCLES(NINIT),
      .T_RAS(T_RAS), .T_RCD(T_RCD), .T_ASC(T_ASC), .T_CAS(T_CAS), .T_CSR(T_CSR),
      .T_CHR(T_CHR), .T_CP(T_CP), .T_CAC(T_CAC), .T_OEZ(T_OEZ), .T_WP(T_WP), .T_RP(T_RP)
   ) i_dram_cbr_counter_test (
      .clk(clk), .rst_n(rst_n), .start(start), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe),
      .dq_in(dq_in), .busy(busy), .done(done), .fail(fail), .fail_round(fail_round),
      .fail_pass(fail_pass), .fail_row(fail_row), .fail_data(fail_data)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- DRAM model with its own refresh counter ----------------
   logic [DW-1:0] mem [N];
   int fault = 0, fault_arg = 0;
   logic [RW-1:0] seed_cnt = '0;
   logic [RW-1:0] m_cnt = '0, m_row = '0, m_col = '0, nw_next = '0, nr_next = '0;
   int ror_cnt, ror_bad, ord_err, col_err, cbr_wr, n_rd, inc_n;
   bit prev_ras = 1, prev_cas = 1, prev_we = 1, act = 0, cbr = 0, ror_c = 0;

   assign dq_in = (act && !oe_n && !cas_n) ? mem[m_row] : 16'hDEAD;

   task automatic m_write();
      logic [DW-1:0] w;
      w = dq_oe ? dq_out : 16'h5A5A;
      if (m_col != RW'(TCOL)) w = ~w;
      if (cbr) begin
         cbr_wr++;
         if (!(fault == 2 && int'(m_row) == fault_arg)) mem[m_row] = w;
      end else begin
         mem[m_row] = w;
         if (m_row != nw_next) ord_err++;
         nw_next = nw_next + 1'b1;
      end
   endtask

   always @(negedge clk) begin
      if (start && !busy) begin
         ror_cnt = 0; ror_bad = 0; ord_err = 0; col_err = 0; cbr_wr = 0; n_rd = 0; inc_n = 0;
         m_cnt = seed_cnt; nw_next = '0; nr_next = '0;
      end
      if (prev_ras && !ras_n) begin
         cbr   = !cas_n;
         m_row = cbr ? m_cnt : addr;
         ror_c = cas_n;
         act   = 0;
      end
      if (!ras_n && prev_cas && !cas_n) begin
         ror_c = 0;
         act   = 1;
         m_col = addr;
         if (m_col != RW'(TCOL)) col_err++;
         if (!we_n) m_write();
         else if (!cbr) begin
            if (m_row != nr_next) ord_err++;
            nr_next = nr_next + 1'b1;
            n_rd++;
         end
      end else if (act && !cas_n && prev_we && !we_n) m_write();
      if (!prev_cas && cas_n) act = 0;
      if (!prev_ras && ras_n) begin
         if (cbr) begin
            m_cnt = m_cnt + ((fault == 1 && inc_n == fault_arg) ? RW'(2) : RW'(1));
            inc_n++;
         end
         if (ror_c) begin
            ror_cnt++;
            if (int'(m_row) >= NINIT) ror_bad++;
         end
         ror_c = 0; cbr = 0; act = 0;
      end
      prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n;
   end

   // ---------------- expectations ----------------
   function automatic int exp_cycles();
      int wr_c, rd_c, cbr_c;
      wr_c  = T_RCD + T_ASC + T_CAS + T_RP;
      rd_c  = T_RCD + T_ASC + T_CAC + T_RP;
      cbr_c = T_CSR + T_CHR + T_CP + T_CAC + T_OEZ + T_WP + T_RP;
      return NINIT * (T_RAS + T_RP) + 2 * N * (wr_c + rd_c + cbr_c);
   endfunction

   function automatic int nonzero_rows();
      int k = 0;
      for (int r = 0; r < N; r++) if (mem[r] != '0) k++;
      return k;
   endfunction

   task automatic run(input int f, input int farg, input bit spam, output int cyc);
      fault = f; fault_arg = farg; seed_cnt = RW'($urandom_range(0, N - 1));
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      cyc = 0;
      while (!done && cyc < 20000) begin
         if (busy) cyc++;
         start = spam ? ($urandom_range(0, 5) == 0) : 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic check_good(input string tag, input int cyc);
      chk("R10", {tag, " done"}, done, 1);
      chk("R10", {tag, " busy low at done"}, busy, 0);
      chk("R9", {tag, " no fail"}, fail, 0);
      chk("R8", {tag, " busy cycles"}, cyc, exp_cycles());
      chk("R1", {tag, " RAS-only count"}, ror_cnt, NINIT);
      chk("R1", {tag, " RAS-only rows"}, ror_bad, 0);
      chk("R2", {tag, " column errors"}, col_err, 0);
      chk("R3", {tag, " explicit order errors"}, ord_err, 0);
      chk("R5", {tag, " counter-test writes"}, cbr_wr, 2 * N);
      chk("R6", {tag, " verify reads"}, n_rd, 2 * N);
      chk("R7", {tag, " nonzero rows at end"}, nonzero_rows(), 0);
   endtask

   task automatic check_fail(input string req, input int pass_e, input int round_e, input int row_e, input int data_e);
      chk("R10", "done after faulty run", done, 1);
      chk("R9", "fail flag", fail, 1);
      chk("R9", "fail pass", fail_pass, pass_e);
      chk(req, "fail round", fail_round, round_e);
      chk(req, "fail row", fail_row, row_e);
      chk(req, "fail data", fail_data, data_e);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int cyc, s, d;
      void'($urandom(32'h1F2E3D4C));
      for (int r = 0; r < N; r++) mem[r] = 16'h1234;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11", "strobes high in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
      chk("R11", "dq_oe low in reset", dq_oe, 0);
      chk("R11", "status low in reset", {busy, done, fail}, 3'b000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11", "idle after reset", {busy, done}, 2'b00);

      run(0, 0, 1'b0, cyc);
      check_good("plain", cyc);
      repeat (5) @(negedge clk);
      chk("R10", "done held", done, 1);
      chk("R10", "strobes quiet while done", {ras_n, cas_n, we_n, oe_n, dq_oe}, 5'b11110);

      // counter skips a row in round 0: duplicate visit found at last cycle
      s = $urandom_range(0, N - 2);
      run(1, s, 1'b0, cyc);
      check_fail("R5", 2, 0, N - 1, 16'hFFFF);

      // counter skips in round 1 only
      s = $urandom_range(0, N - 2);
      run(1, N + s, 1'b0, cyc);
      check_fail("R7", 2, 1, N - 1, 16'h0000);

      // lost counter-test write at random row: caught by verify pass
      d = $urandom_range(0, N - 1);
      run(2, d, 1'b0, cyc);
      check_fail("R6", 3, 0, d, 16'h0000);

      // directed corner: top row lost
      run(2, N - 1, 1'b0, cyc);
      check_fail("R6", 3, 0, N - 1, 16'h0000);

      // start spam while busy must not disturb; fail from previous run cleared
      run(0, 0, 1'b1, cyc);
      check_good("spam", cyc);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule